// File: doc/BRIEF.md
# Instruction Prefetch Queue with Branch-Target Buffer Reuse

This block sits between a line-organised instruction cache and a variable-length instruction decoder. It requests aligned 16-byte blocks from the cache, one request in flight at a time, and keeps them in two 16-byte line buffers. The decoder sees a small byte window (three bytes by default) starting at the current fetch address, and reports each instruction's length. The fetch address then moves forward by that many bytes. A window that runs off the end of one buffer is stitched together from the tail of that buffer and the head of the other.

The controller has two states. In `PF_SEQ` the buffers work as a ping-pong pair: the decoder drains one buffer while the next sequential block lands in the other. A prediction hint (`bp_hint`) takes the transition SEQ→BRANCH. It hands the idle buffer to the predicted target block, and that buffer is filled while decoding continues in the fall-through buffer. `PF_BRANCH` goes back to `PF_SEQ` on any of four transitions:
- **taken resolve**: the target buffer becomes the live stream at once, with no refetch.
- **not-taken resolve**: the target buffer is refilled with the next fall-through block.
- **fall-through crossing**: a consume moves past the current block, so the target path is abandoned.
- **redirect**: a redirect in either state flushes both buffers, discards any in-flight fill, and restarts at the new address. It is a self-transition in `PF_SEQ`.

Top module: `ipfq_top`

## Requirements
- R1: During and directly after reset, `win_ready` is 0, `cur_pc` equals `RESET_ADDR` (default 0x105), and the first request carries the aligned block 0x100.
- R2: Every request address has its low four bits zero. At most one request is in flight. A returning line is written only into an empty buffer. Byte j of `resp_data` (bits 8j+7:8j) is the byte at request address + j.
- R3: When `win_ready` is 1, byte i of `win_bytes` (bits 8i+7:8i) is the instruction byte at address `cur_pc`+i.
- R4: A `consume` with length 1..16 that is accepted while `win_ready` is 1 adds the length to `cur_pc` at the next edge. A `consume` while `win_ready` is 0 leaves `cur_pc` unchanged.
- R5: A window that spans two blocks is assembled from both buffers. In `PF_SEQ` it becomes ready once the following block is loaded.
- R6: When the fetch address leaves a block, that buffer is refilled with the block two ahead, so a sequential run never stalls for longer than a fill.
- R7: A redirect sets `cur_pc` to the redirect address at the next edge and invalidates both buffers. Any fill that was in flight is discarded, so back-to-back redirects yield the bytes of the last target.
- R8: In `PF_SEQ`, `bp_hint` loads the idle buffer with the block holding `bp_target` and enters `PF_BRANCH`. A hint received in `PF_BRANCH` is ignored.
- R9: In `PF_BRANCH`, a window that needs bytes past the end of the current block stays not ready.
- R10: A taken resolve sets `cur_pc` to the hinted target at the next edge. If the target block has already arrived and the window fits in it, `win_ready` is 1 in that same cycle.
- R11: A not-taken resolve leaves `cur_pc` unchanged and reloads the idle buffer with the next sequential block. A resolve in `PF_SEQ` is ignored.
- R12: A consume in `PF_BRANCH` that moves past the current block abandons the target path and continues sequentially from the new address.
- R13: A redirect takes priority over everything else. A resolve in `PF_BRANCH`, or a hint in `PF_SEQ`, in the same cycle as a consume causes the consume to be ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | output | 1 | Line request to the cache |
| req_ready | input | 1 | Cache accepts the request |
| req_addr | output | AW | Aligned block address of the request |
| resp_valid | input | 1 | Line data returned (in order) |
| resp_data | input | 8*LINE_BYTES | Returned line, byte j at bits 8j+7:8j |
| redirect | input | 1 | Flush and restart at `redirect_addr` |
| redirect_addr | input | AW | New fetch address |
| bp_hint | input | 1 | Predicted branch, prefetch its target |
| bp_target | input | AW | Predicted target address |
| br_resolve | input | 1 | Prediction outcome is known |
| br_taken | input | 1 | Outcome: 1 taken, 0 not taken |
| consume | input | 1 | Decoder consumes one instruction |
| consume_len | input | LENW | Instruction length in bytes, 1..LINE_BYTES |
| win_bytes | output | 8*WIN | Byte window at `cur_pc` |
| win_ready | output | 1 | All window bytes present |
| cur_pc | output | AW | Current fetch byte address |

## Verification
Consume lengths are swept from 1 to 16 across a long sequential run. This shows whether the pointer arithmetic and the ping-pong refill keep the window correct as it crosses blocks at every phase. Every start offset is tried behind a pair of back-to-back redirects. This separates correct offset handling from a stale fill that arrives after a flush. A grid of offsets 10..15 against all lengths exercises the stitched windows that cross a block boundary. Directed branch sequences separate the outcomes from one another: a taken resolve with a preloaded target, a not-taken resolve at a boundary offset, a fall-through crossing in `PF_BRANCH`, ignored hints, ignored resolves, and consumes that collide with control inputs.

// File: rtl/ipfq_pkg.sv
package ipfq_pkg;

    typedef enum logic {
        PF_SEQ    = 1'b0,
        PF_BRANCH = 1'b1
    } pf_mode_e;

endpackage

// File: rtl/ipfq_window.sv
module ipfq_window #(
    parameter int LINE_BYTES = 16,
    parameter int WIN        = 3,
    parameter int OFFW       = $clog2(LINE_BYTES)
) (
    input  logic [LINE_BYTES*8-1:0] line_cur,
    input  logic [LINE_BYTES*8-1:0] line_alt,
    input  logic [OFFW-1:0]         off,
    input  logic                    cur_vld,
    input  logic                    alt_vld,
    input  logic                    alt_seq,
    output logic [WIN*8-1:0]        bytes,
    output logic                    ready
);

    logic [WIN-1:0] from_alt;

    for (genvar i = 0; i < WIN; i++) begin : g_byte
        logic [OFFW:0]   pos;
        logic [OFFW+2:0] bit_base;
        assign pos      = {1'b0, off} + (OFFW+1)'(i);
        assign bit_base = {pos[OFFW-1:0], 3'b000};
        assign from_alt[i] = pos[OFFW];
        assign bytes[i*8 +: 8] = pos[OFFW] ? line_alt[bit_base +: 8]
                                           : line_cur[bit_base +: 8];
    end

    // The last window byte is the furthest one, so it decides the need for the other buffer.
    assign ready = cur_vld && (!from_alt[WIN-1] || (alt_vld && alt_seq));

endmodule

// File: rtl/ipfq_fill.sv
module ipfq_fill #(
    parameter int AW   = 32,
    parameter int OFFW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       vld,
    input  logic             cur,
    input  logic [AW-OFFW-1:0] blk0,
    input  logic [AW-OFFW-1:0] blk1,
    input  logic [1:0]       kill,
    input  logic             req_ready,
    input  logic             resp_valid,
    output logic             req_valid,
    output logic [AW-1:0]    req_addr,
    output logic             wr_en,
    output logic             wr_idx
);

    logic pend_q;
    logic drop_q;
    logic idx_q;
    logic tidx;
    logic need;

    always_comb begin
        tidx      = vld[cur] ? ~cur : cur;
        need      = ~&vld;
        req_valid = need && !pend_q && !(|kill);
        req_addr  = {(tidx ? blk1 : blk0), {OFFW{1'b0}}};
        wr_en     = resp_valid && pend_q && !drop_q && !kill[idx_q];
        wr_idx    = idx_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            drop_q <= 1'b0;
            idx_q  <= 1'b0;
        end else if (req_valid && req_ready) begin
            pend_q <= 1'b1;
            drop_q <= 1'b0;
            idx_q  <= tidx;
        end else if (resp_valid && pend_q) begin
            pend_q <= 1'b0;
        end else if (pend_q && kill[idx_q]) begin
            drop_q <= 1'b1;
        end
    end

    // R2
    fill_into_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !vld[wr_idx]);

    // R7
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && kill[idx_q]) |=> !wr_en);

endmodule

// File: rtl/ipfq_top.sv
module ipfq_top
    import ipfq_pkg::*;
#(
    parameter int          AW         = 32,
    parameter int          LINE_BYTES = 16,
    parameter int          WIN        = 3,
    parameter logic [31:0] RESET_ADDR = 32'h0000_0105,
    parameter int          LENW       = $clog2(LINE_BYTES) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [AW-1:0]           req_addr,
    input  logic                    resp_valid,
    input  logic [LINE_BYTES*8-1:0] resp_data,
    input  logic                    redirect,
    input  logic [AW-1:0]           redirect_addr,
    input  logic                    bp_hint,
    input  logic [AW-1:0]           bp_target,
    input  logic                    br_resolve,
    input  logic                    br_taken,
    input  logic                    consume,
    input  logic [LENW-1:0]         consume_len,
    output logic [WIN*8-1:0]        win_bytes,
    output logic                    win_ready,
    output logic [AW-1:0]           cur_pc
);

    localparam int OFFW = $clog2(LINE_BYTES);
    localparam int BLKW = AW - OFFW;
    localparam int LW   = LINE_BYTES * 8;
    localparam logic [OFFW-1:0] LAST_FULL = OFFW'(LINE_BYTES - WIN);
    localparam logic [AW-1:0]   RST_A     = AW'(RESET_ADDR);

    pf_mode_e state_q, state_d;

    logic [LW-1:0]   line_q [2];
    logic [BLKW-1:0] blk_q  [2];
    logic [1:0]      vld_q;
    logic            cur_q;
    logic            alt;
    logic [OFFW-1:0] off_q;
    logic [OFFW-1:0] tgt_off_q;

    logic            ev_taken, ev_ntaken, ev_hint, ev_cons, ev_cross;
    logic [LENW-1:0] sum;
    logic [1:0]      kill;
    logic            wr_en, wr_idx;

    assign alt = ~cur_q;

    // ---------------- event decode ----------------
    always_comb begin
        ev_taken  = !redirect && (state_q == PF_BRANCH) && br_resolve &&  br_taken;
        ev_ntaken = !redirect && (state_q == PF_BRANCH) && br_resolve && !br_taken;
        ev_hint   = !redirect && (state_q == PF_SEQ) && bp_hint;
        ev_cons   = !redirect && !ev_taken && !ev_ntaken && !ev_hint &&
                    consume && win_ready;
        sum       = {1'b0, off_q} + consume_len;
        ev_cross  = ev_cons && sum[OFFW];
    end

    // Buffers whose base or contents are reassigned this cycle.
    always_comb begin
        kill = 2'b00;
        if (redirect) begin
            kill = 2'b11;
        end else if (ev_taken) begin
            kill[cur_q] = 1'b1;
        end else if (ev_ntaken || ev_hint) begin
            kill[alt] = 1'b1;
        end else if (ev_cross) begin
            kill[cur_q] = 1'b1;
            if (state_q == PF_BRANCH) kill[alt] = 1'b1;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PF_SEQ;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_SEQ: begin
                if (ev_hint) state_d = PF_BRANCH;
            end
            PF_BRANCH: begin
                if (redirect || br_resolve || ev_cross) state_d = PF_SEQ;
            end
        endcase
    end

    // ---------------- buffers and pointer ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q     <= 2'b00;
            blk_q[0]  <= RST_A[AW-1:OFFW];
            blk_q[1]  <= RST_A[AW-1:OFFW] + BLKW'(1);
            cur_q     <= 1'b0;
            off_q     <= RST_A[OFFW-1:0];
            tgt_off_q <= '0;
        end else begin
            if (wr_en) begin
                line_q[wr_idx] <= resp_data;
                vld_q[wr_idx]  <= 1'b1;
            end
            if (redirect) begin
                vld_q    <= 2'b00;
                blk_q[0] <= redirect_addr[AW-1:OFFW];
                blk_q[1] <= redirect_addr[AW-1:OFFW] + BLKW'(1);
                cur_q    <= 1'b0;
                off_q    <= redirect_addr[OFFW-1:0];
            end else if (ev_taken) begin
                cur_q        <= alt;
                off_q        <= tgt_off_q;
                blk_q[cur_q] <= blk_q[alt] + BLKW'(1);
                vld_q[cur_q] <= 1'b0;
            end else if (ev_ntaken) begin
                blk_q[alt] <= blk_q[cur_q] + BLKW'(1);
                vld_q[alt] <= 1'b0;
            end else if (ev_hint) begin
                blk_q[alt] <= bp_target[AW-1:OFFW];
                vld_q[alt] <= 1'b0;
                tgt_off_q  <= bp_target[OFFW-1:0];
            end else if (ev_cons) begin
                off_q <= sum[OFFW-1:0];
                if (ev_cross) begin
                    cur_q        <= alt;
                    blk_q[cur_q] <= blk_q[cur_q] + BLKW'(2);
                    vld_q[cur_q] <= 1'b0;
                    if (state_q == PF_BRANCH) begin
                        blk_q[alt] <= blk_q[cur_q] + BLKW'(1);
                        vld_q[alt] <= 1'b0;
                    end
                end
            end
        end
    end

    // ---------------- submodules ----------------
    ipfq_fill #(.AW(AW), .OFFW(OFFW)) u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld        (vld_q),
        .cur        (cur_q),
        .blk0       (blk_q[0]),
        .blk1       (blk_q[1]),
        .kill       (kill),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx)
    );

    ipfq_window #(.LINE_BYTES(LINE_BYTES), .WIN(WIN), .OFFW(OFFW)) u_win (
        .line_cur (line_q[cur_q]),
        .line_alt (line_q[alt]),
        .off      (off_q),
        .cur_vld  (vld_q[cur_q]),
        .alt_vld  (vld_q[alt]),
        .alt_seq  (state_q == PF_SEQ),
        .bytes    (win_bytes),
        .ready    (win_ready)
    );

    // ---------------- outputs ----------------
    always_comb begin
        cur_pc = {blk_q[cur_q], off_q};
    end

    // ---------------- assertions ----------------
    // R7
    redirect_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> cur_pc == $past(redirect_addr));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && win_ready && !redirect && !bp_hint && !br_resolve)
        |=> cur_pc == $past(cur_pc + AW'(consume_len)));

    // R4
    hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!consume && !redirect && !br_resolve) |=> $stable(cur_pc));

    // R9
    branch_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PF_BRANCH && off_q > LAST_FULL) |-> !win_ready);

endmodule

// File: tb/ipfq_top_test.sv
module ipfq_top_test;

    localparam int AW = 32;
    localparam int LB = 16;
    localparam int WIN = 3;
    localparam int LENW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid, req_ready;
    logic [AW-1:0] req_addr;
    logic resp_valid = 1'b0;
    logic [LB*8-1:0] resp_data = '0;
    logic redirect = 1'b0;
    logic [AW-1:0] redirect_addr = '0;
    logic bp_hint = 1'b0;
    logic [AW-1:0] bp_target = '0;
    logic br_resolve = 1'b0;
    logic br_taken = 1'b0;
    logic consume = 1'b0;
    logic [LENW-1:0] consume_len = '0;
    logic [WIN*8-1:0] win_bytes;
    logic win_ready;
    logic [AW-1:0] cur_pc;

    int n_tests = 0;
    int n_fail = 0;
    int bad_align = 0;
    bit done = 0;
    logic [31:0] pc;
    logic [1:0] rdy_cnt = '0;

    always #2 clk = ~clk;

    ipfq_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
        .redirect(redirect), .redirect_addr(redirect_addr), .bp_hint(bp_hint),
        .bp_target(bp_target), .br_resolve(br_resolve), .br_taken(br_taken),
        .consume(consume), .consume_len(consume_len), .win_bytes(win_bytes),
        .win_ready(win_ready), .cur_pc(cur_pc)
    );

    function automatic logic [7:0] mb(input logic [31:0] a);
        return a[7:0] * 8'd29 + a[15:8] + 8'd7;
    endfunction

    function automatic logic [WIN*8-1:0] exp_win(input logic [31:0] a);
        logic [WIN*8-1:0] w;
        for (int i = 0; i < WIN; i++) w[i*8 +: 8] = mb(a + 32'(i));
        return w;
    endfunction

    // Cache model: one-cycle latency, accepts three cycles out of four.
    assign req_ready = (rdy_cnt != 2'b11);
    always @(posedge clk) begin
        rdy_cnt <= rdy_cnt + 2'd1;
        if (!rst_n) begin
            resp_valid <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            if (req_valid && req_addr[3:0] != 4'h0) bad_align <= bad_align + 1;
            if (req_valid && req_ready) begin
                resp_valid <= 1'b1;
                for (int j = 0; j < LB; j++) resp_data[j*8 +: 8] <= mb(req_addr + 32'(j));
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_win(input string tag);
        int k;
        k = 0;
        while (!win_ready && k < 60) begin
            tick();
            k++;
        end
        check({tag, " ready"}, 64'(win_ready), 64'd1);
        if (win_ready) begin
            check({tag, " pc"}, 64'(cur_pc), 64'(pc));
            check({tag, " bytes"}, 64'(win_bytes), 64'(exp_win(pc)));
        end
    endtask

    task automatic do_redirect(input logic [31:0] a);
        redirect = 1'b1; redirect_addr = a;
        tick();
        redirect = 1'b0;
        pc = a;
    endtask

    task automatic do_consume(input int len);
        consume = 1'b1; consume_len = LENW'(len);
        tick();
        consume = 1'b0;
        pc = pc + 32'(len);
    endtask

    task automatic do_hint(input logic [31:0] t);
        bp_hint = 1'b1; bp_target = t;
        tick();
        bp_hint = 1'b0;
    endtask

    task automatic do_resolve(input logic tk);
        br_resolve = 1'b1; br_taken = tk;
        tick();
        br_resolve = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        check("R1 ready in reset", 64'(win_ready), 64'd0);
        rst_n = 1'b1;
        check("R1 ready after reset", 64'(win_ready), 64'd0);
        check("R1 pc", 64'(cur_pc), 64'h105);
        check("R1 first req valid", 64'(req_valid), 64'd1);
        check("R1 first req addr", 64'(req_addr), 64'h100);
        pc = 32'h105;
        check_win("R3 first window");

        // R4 R6: sequential sweep of all lengths
        for (int len = 1; len <= LB; len++) begin
            do_consume(len);
            check_win("R4 R6 sweep");
        end

        // R7: all offsets behind back-to-back redirects
        for (int o = 0; o < LB; o++) begin
            do_redirect(32'h5550 + 32'(o * 32));
            do_redirect(32'h2000 + 32'(o * 64) + 32'(o));
            check("R7 pc after redirect", 64'(cur_pc), 64'(pc));
            check_win("R7 redirect window");
        end

        // R5: boundary-crossing grid
        for (int off = 10; off < LB; off++) begin
            for (int len = 1; len <= LB; len++) begin
                do_redirect(32'h4000 + 32'(len * 256) + 32'(off));
                check_win("R5 start");
                do_consume(len);
                check_win("R5 after consume");
            end
        end

        // R4: consume while not ready is ignored
        do_redirect(32'h3337);
        check("R4 not ready", 64'(win_ready), 64'd0);
        consume = 1'b1; consume_len = 5'd5;
        tick();
        consume = 1'b0;
        check_win("R4 ignored consume");

        // R8 R10: taken branch with preloaded target; second hint ignored
        do_redirect(32'h6002);
        check_win("R10 pre");
        do_hint(32'h8005);
        repeat (10) tick();
        do_hint(32'h9009);
        repeat (10) tick();
        do_resolve(1'b1);
        pc = 32'h8005;
        check("R10 ready same cycle", 64'(win_ready), 64'd1);
        check("R8 R10 pc target", 64'(cur_pc), 64'(pc));
        check("R10 bytes", 64'(win_bytes), 64'(exp_win(pc)));
        do_consume(13);
        check_win("R10 continue after target");

        // R9 R11: not-taken at a crossing offset
        do_redirect(32'h600E);
        check_win("R5 crossing seq");
        do_hint(32'hA000);
        check("R9 not ready", 64'(win_ready), 64'd0);
        repeat (10) tick();
        check("R9 still not ready", 64'(win_ready), 64'd0);
        consume = 1'b1; consume_len = 5'd2;
        tick();
        consume = 1'b0;
        do_resolve(1'b0);
        check("R11 pc kept", 64'(cur_pc), 64'(pc));
        check_win("R11 not-taken window");

        // R12: fall-through crossing abandons the target path
        do_redirect(32'h6103);
        check_win("R12 pre");
        do_hint(32'hB000);
        check_win("R12 branch in-block");
        do_consume(15);
        check_win("R12 crossed");
        do_resolve(1'b1);
        check("R12 resolve ignored pc", 64'(cur_pc), 64'(pc));
        check_win("R12 after ignored resolve");

        // R13: priority
        consume = 1'b1; consume_len = 5'd4;
        redirect = 1'b1; redirect_addr = 32'h7007;
        tick();
        consume = 1'b0; redirect = 1'b0;
        pc = 32'h7007;
        check("R13 redirect wins", 64'(cur_pc), 64'(pc));
        check_win("R13 redirect window");
        bp_hint = 1'b1; bp_target = 32'hC000;
        consume = 1'b1; consume_len = 5'd3;
        tick();
        bp_hint = 1'b0; consume = 1'b0;
        check("R13 hint wins over consume", 64'(cur_pc), 64'(pc));
        do_resolve(1'b0);
        check_win("R13 after resolve");

        // R2: alignment of every request
        check("R2 aligned requests", 64'(bad_align), 64'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule